// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block merges the interrupt sources of two serial channels (channel A is index 0, channel B is index 1) into a single interrupt request line. Each channel has three sources: a received character, a loaded transmit buffer and a detected line break. Within a channel, receive and transmit service exclude each other. Whichever of the two claims service first owns the shared vector byte. When that source is cleared, the other one is promoted if it is still pending.

The block keeps one shared vector register and one shared pending byte. The vector codes either sit in the low bits or in the high bits, depending on a status-position control input. The host side of the chip drives one-cycle command strobes into the block: a read of the data port, a transmit-interrupt clear and a reset-highest-in-service command. The register interface supplies the per-channel enable bits. Decoding of the register addresses is done elsewhere.

Top module: `duart_irq_vec`

## Requirements
- R1: While `rst` is high and right after it falls, `irq` is 0, `vec` is 0x06 and `pend` is 0x00. Reset also clears every pending, in-service and break flag.
- R2: A channel requests an interrupt only when its master enable is 1 and at least one of these enabled sources is pending:
  - transmit pending with its transmit enable set;
  - receive pending with its two-bit receive mode equal to 01 or 10;
  - break status set with its break enable set.
  The break status is set by a break strobe and stays set until reset.
- R3: `irq` is the OR of both channel requests. It is registered: it reflects the state and enables present at the previous clock edge.
- R4: `pend` bit layout: bit 5 is A receive, bit 4 is A transmit, bit 2 is B receive and bit 1 is B transmit. Bits 7, 6, 3 and 0 read 0.
- R5: A receive strobe sets that channel's receive pending flag. It claims in-service and writes its vector code only when transmit of the same channel is not in service. A transmit strobe behaves the same way with the roles swapped. A channel never has both in service at once.
- R6: With `stat_hi` = 0 the vector codes are: no interrupt 0x06, A receive 0x0C, A transmit 0x08, B receive 0x04.
- R7: With `stat_hi` = 1 the vector codes are: no interrupt 0x60, A receive 0x30, A transmit 0x10, B receive 0x20. B transmit writes 0x00 in both positions. The code uses the value of `stat_hi` in the cycle the vector is written.
- R8: Clearing receive or transmit drops that source's pending and in-service flags and writes the no-interrupt code. If the other source of the channel is still pending, it is then set again: it re-claims service and writes its code when the normal rule of R5 allows.
- R9: The reset-highest-in-service strobe clears receive if receive is in service. Otherwise it clears transmit if transmit is in service. Otherwise it does nothing.
- R10: A data-port read strobe clears the channel's receive interrupt, following the clear rule of R8.
- R11: Within one cycle a channel applies its operations in this order: reset-highest-in-service, data read, transmit clear, receive strobe, transmit strobe. When both channels write the vector in the same cycle, channel B's final code wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | 2 | Character-received strobe per channel |
| tx_evt | input | 2 | Transmit-buffer-loaded strobe per channel |
| brk_evt | input | 2 | Break-detected strobe per channel |
| data_rd | input | 2 | Data-port read strobe per channel |
| clr_tx | input | 2 | Transmit-interrupt clear strobe per channel |
| clr_ius | input | 2 | Reset-highest-in-service strobe per channel |
| ie_master | input | 2 | Master interrupt enable per channel |
| ie_tx | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, bits [2c+1:2c] for channel c |
| ie_brk | input | 2 | Break interrupt enable per channel |
| stat_hi | input | 1 | 1 selects the high-bit vector codes |
| irq | output | 1 | Registered interrupt request |
| vec | output | 8 | Shared interrupt vector |
| pend | output | 8 | Shared interrupt-pending byte |

## Verification
The assertions check four things on every cycle:
- the vector only ever holds one of the nine legal codes;
- the unused pending bits stay 0;
- no channel ever has receive and transmit in service together;
- single strobes have the effect that R2, R5, R7 and R10 require on the next cycle.

Some behaviours can only be shown by the bench scenarios, which compare against a reference model on every clock. These are the promotion of the other source after a clear, the choice of the reset-highest-in-service command, the same-cycle ordering inside a channel and between channels, and the persistence of the break status across enable changes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NCH = 2;
  localparam int VW  = 8;
  localparam int MW  = 2;

  typedef logic [VW-1:0] vec_t;

  typedef struct packed {
    logic rxp;
    logic txp;
    logic rxs;
    logic txs;
    logic vwr;
    vec_t vcode;
  } chs_t;

  function automatic vec_t code_none(logic hi);
    return hi ? vec_t'(8'h60) : vec_t'(8'h06);
  endfunction

  function automatic vec_t code_of(int ch, logic is_tx, logic hi);
    vec_t c;
    if (ch == 0) begin
      if (is_tx) c = hi ? vec_t'(8'h10) : vec_t'(8'h08);
      else       c = hi ? vec_t'(8'h30) : vec_t'(8'h0C);
    end else begin
      if (is_tx) c = vec_t'(8'h00);
      else       c = hi ? vec_t'(8'h20) : vec_t'(8'h04);
    end
    return c;
  endfunction

  function automatic chs_t do_set_rx(chs_t s, vec_t rxc);
    chs_t r = s;
    r.rxp = 1'b1;
    if (!r.txs) begin
      r.rxs   = 1'b1;
      r.vwr   = 1'b1;
      r.vcode = rxc;
    end
    return r;
  endfunction

  function automatic chs_t do_set_tx(chs_t s, vec_t txc);
    chs_t r = s;
    r.txp = 1'b1;
    if (!r.rxs) begin
      r.txs   = 1'b1;
      r.vwr   = 1'b1;
      r.vcode = txc;
    end
    return r;
  endfunction

  function automatic chs_t do_clr_rx(chs_t s, vec_t nc, vec_t txc);
    chs_t r = s;
    r.rxp   = 1'b0;
    r.rxs   = 1'b0;
    r.vwr   = 1'b1;
    r.vcode = nc;
    if (r.txp) r = do_set_tx(r, txc);
    return r;
  endfunction

  function automatic chs_t do_clr_tx(chs_t s, vec_t nc, vec_t rxc);
    chs_t r = s;
    r.txp   = 1'b0;
    r.txs   = 1'b0;
    r.vwr   = 1'b1;
    r.vcode = nc;
    if (r.rxp) r = do_set_rx(r, rxc);
    return r;
  endfunction
endpackage

// File: rtl/irqv_chan.sv
module irqv_chan
  import irqv_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic brk_evt,
  input  logic data_rd,
  input  logic clr_tx,
  input  logic clr_ius,
  input  logic stat_hi,
  output logic rxp,
  output logic txp,
  output logic rxs,
  output logic txs,
  output logic brk,
  output logic vwr,
  output vec_t vcode
);
  chs_t st_q;
  chs_t st_n;
  logic brk_q;
  vec_t rx_code, tx_code, no_code;

  always_comb begin
    rx_code = code_of(CH, 1'b0, stat_hi);
    tx_code = code_of(CH, 1'b1, stat_hi);
    no_code = code_none(stat_hi);
  end

  // ordered operation sequence for one cycle (R11)
  always_comb begin
    st_n       = st_q;
    st_n.vwr   = 1'b0;
    st_n.vcode = '0;
    if (clr_ius) begin
      if (st_n.rxs)      st_n = do_clr_rx(st_n, no_code, tx_code);
      else if (st_n.txs) st_n = do_clr_tx(st_n, no_code, rx_code);
    end
    if (data_rd) st_n = do_clr_rx(st_n, no_code, tx_code);
    if (clr_tx)  st_n = do_clr_tx(st_n, no_code, rx_code);
    if (rx_evt)  st_n = do_set_rx(st_n, rx_code);
    if (tx_evt)  st_n = do_set_tx(st_n, tx_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      brk_q <= 1'b0;
    end else begin
      st_q.rxp   <= st_n.rxp;
      st_q.txp   <= st_n.txp;
      st_q.rxs   <= st_n.rxs;
      st_q.txs   <= st_n.txs;
      st_q.vwr   <= 1'b0;
      st_q.vcode <= '0;
      if (brk_evt) brk_q <= 1'b1;
    end
  end

  assign rxp   = st_q.rxp;
  assign txp   = st_q.txp;
  assign rxs   = st_q.rxs;
  assign txs   = st_q.txs;
  assign brk   = brk_q;
  assign vwr   = st_n.vwr;
  assign vcode = st_n.vcode;
endmodule

// File: rtl/irqv_req.sv
module irqv_req
  import irqv_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic [N-1:0]    ie_master,
  input  logic [N-1:0]    ie_tx,
  input  logic [MW*N-1:0] rx_mode,
  input  logic [N-1:0]    ie_brk,
  input  logic [N-1:0]    rxp,
  input  logic [N-1:0]    txp,
  input  logic [N-1:0]    brk,
  output logic [N-1:0]    req
);
  for (genvar c = 0; c < N; c++) begin : g_req
    logic [MW-1:0] md;
    logic          rx_on;
    assign md    = rx_mode[MW*c +: MW];
    assign rx_on = (md == 2'b01) || (md == 2'b10);
    assign req[c] = ie_master[c] &
                    ((ie_tx[c] & txp[c]) | (rx_on & rxp[c]) | (ie_brk[c] & brk[c]));
  end
endmodule

// File: rtl/duart_irq_vec.sv
module duart_irq_vec
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    rx_evt,
  input  logic [NCH-1:0]    tx_evt,
  input  logic [NCH-1:0]    brk_evt,
  input  logic [NCH-1:0]    data_rd,
  input  logic [NCH-1:0]    clr_tx,
  input  logic [NCH-1:0]    clr_ius,
  input  logic [NCH-1:0]    ie_master,
  input  logic [NCH-1:0]    ie_tx,
  input  logic [MW*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]    ie_brk,
  input  logic              stat_hi,
  output logic              irq,
  output logic [VW-1:0]     vec,
  output logic [VW-1:0]     pend
);
  logic [NCH-1:0]         rxp_w, txp_w, rx_svc, tx_svc, brk_w, vwr_w, req_w;
  logic [NCH-1:0][VW-1:0] vcode_w;
  vec_t                   vec_q, vec_n;
  logic                   irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irqv_chan #(.CH(c)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .rx_evt  (rx_evt[c]),
      .tx_evt  (tx_evt[c]),
      .brk_evt (brk_evt[c]),
      .data_rd (data_rd[c]),
      .clr_tx  (clr_tx[c]),
      .clr_ius (clr_ius[c]),
      .stat_hi (stat_hi),
      .rxp     (rxp_w[c]),
      .txp     (txp_w[c]),
      .rxs     (rx_svc[c]),
      .txs     (tx_svc[c]),
      .brk     (brk_w[c]),
      .vwr     (vwr_w[c]),
      .vcode   (vcode_w[c])
    );
  end

  irqv_req #(.N(NCH)) u_req (
    .ie_master (ie_master),
    .ie_tx     (ie_tx),
    .rx_mode   (rx_mode),
    .ie_brk    (ie_brk),
    .rxp       (rxp_w),
    .txp       (txp_w),
    .brk       (brk_w),
    .req       (req_w)
  );

  // higher channel index writes last and wins (R11)
  always_comb begin
    vec_n = vec_q;
    for (int c = 0; c < NCH; c++) begin
      if (vwr_w[c]) vec_n = vcode_w[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= code_none(1'b0);
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_n;
      irq_q <= |req_w;
    end
  end

  assign irq  = irq_q;
  assign vec  = vec_q;
  assign pend = {2'b00, rxp_w[0], txp_w[0], 1'b0, rxp_w[1], txp_w[1], 1'b0};
endmodule

// File: rtl/duart_irq_vec_chk.sv
module duart_irq_vec_chk
  import irqv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    rx_evt,
  input logic [NCH-1:0]    tx_evt,
  input logic [NCH-1:0]    data_rd,
  input logic [NCH-1:0]    clr_tx,
  input logic [NCH-1:0]    clr_ius,
  input logic [NCH-1:0]    ie_master,
  input logic              stat_hi,
  input logic [NCH-1:0]    rxs,
  input logic [NCH-1:0]    txs,
  input logic              irq,
  input logic [VW-1:0]     vec,
  input logic [VW-1:0]     pend
);
  a_r2_no_master_no_irq: assert property (@(posedge clk) disable iff (rst)
    ($past(ie_master) == '0) |-> !irq);

  a_r4_unused_pend_zero: assert property (@(posedge clk) disable iff (rst)
    (pend[7:6] == 2'b00) && !pend[3] && !pend[0]);

  a_r5_svc_exclusive: assert property (@(posedge clk) disable iff (rst)
    (rxs & txs) == '0);

  a_r5_rx_a_sets: assert property (@(posedge clk) disable iff (rst)
    rx_evt[0] |=> pend[5]);

  a_r5_rx_b_sets: assert property (@(posedge clk) disable iff (rst)
    rx_evt[1] |=> pend[2]);

  a_r5_tx_a_sets: assert property (@(posedge clk) disable iff (rst)
    tx_evt[0] |=> pend[4]);

  // R6 and R7: only legal codes appear
  a_r6_vec_legal: assert property (@(posedge clk) disable iff (rst)
    vec inside {8'h06, 8'h0C, 8'h08, 8'h04, 8'h60, 8'h30, 8'h10, 8'h20, 8'h00});

  a_r6_a_rx_code: assert property (@(posedge clk) disable iff (rst)
    (rx_evt[0] && !tx_svc_a && !tx_evt[0] && !data_rd[0] && !clr_tx[0] &&
     !clr_ius[0] && !b_busy) |=> (vec == ($past(stat_hi) ? 8'h30 : 8'h0C)));

  a_r7_b_tx_code: assert property (@(posedge clk) disable iff (rst)
    (tx_evt[1] && !rxs[1] && !rx_evt[1] && !data_rd[1] && !clr_tx[1] &&
     !clr_ius[1]) |=> (vec == 8'h00));

  a_r10_read_clears_rx: assert property (@(posedge clk) disable iff (rst)
    (data_rd[0] && !rx_evt[0]) |=> !pend[5]);

  a_r8_clear_drops_tx: assert property (@(posedge clk) disable iff (rst)
    (clr_tx[1] && !tx_evt[1]) |=> !pend[1]);

  logic tx_svc_a, b_busy;
  assign tx_svc_a = txs[0];
  assign b_busy   = rx_evt[1] | tx_evt[1] | data_rd[1] | clr_tx[1] | clr_ius[1];
endmodule

bind duart_irq_vec duart_irq_vec_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_evt    (rx_evt),
  .tx_evt    (tx_evt),
  .data_rd   (data_rd),
  .clr_tx    (clr_tx),
  .clr_ius   (clr_ius),
  .ie_master (ie_master),
  .stat_hi   (stat_hi),
  .rxs       (rx_svc),
  .txs       (tx_svc),
  .irq       (irq),
  .vec       (vec),
  .pend      (pend)
);

// File: tb/duart_irq_vec_test.sv
module duart_irq_vec_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rx_evt = '0, tx_evt = '0, brk_evt = '0, data_rd = '0, clr_tx = '0, clr_ius = '0;
  logic [1:0] ie_master = 2'b11, ie_tx = 2'b11, ie_brk = 2'b00;
  logic [3:0] rx_mode = 4'b0101;
  logic       stat_hi = 1'b0;
  logic       irq;
  logic [7:0] vec, pend;

  int checks = 0, fails = 0;
  bit done = 0;

  int mrx[2], mtx[2], mri[2], mti[2], mbrk[2];
  int mvec, exp_irq;

  always #5 clk = ~clk;

  duart_irq_vec uut (
    .clk(clk), .rst(rst), .rx_evt(rx_evt), .tx_evt(tx_evt), .brk_evt(brk_evt),
    .data_rd(data_rd), .clr_tx(clr_tx), .clr_ius(clr_ius), .ie_master(ie_master),
    .ie_tx(ie_tx), .rx_mode(rx_mode), .ie_brk(ie_brk), .stat_hi(stat_hi),
    .irq(irq), .vec(vec), .pend(pend)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int code(int c, int is_tx);
    if (c == 1 && is_tx == 1) return 'h00;
    if (stat_hi) return (c == 0) ? (is_tx ? 'h10 : 'h30) : 'h20;
    return (c == 0) ? (is_tx ? 'h08 : 'h0C) : 'h04;
  endfunction

  task automatic m_set_rx(int c);
    mrx[c] = 1;
    if (mti[c] == 0) begin mri[c] = 1; mvec = code(c, 0); end
  endtask
  task automatic m_set_tx(int c);
    mtx[c] = 1;
    if (mri[c] == 0) begin mti[c] = 1; mvec = code(c, 1); end
  endtask
  task automatic m_clr_rx(int c);
    mrx[c] = 0; mri[c] = 0; mvec = stat_hi ? 'h60 : 'h06;
    if (mtx[c] != 0) m_set_tx(c);
  endtask
  task automatic m_clr_tx(int c);
    mtx[c] = 0; mti[c] = 0; mvec = stat_hi ? 'h60 : 'h06;
    if (mrx[c] != 0) m_set_rx(c);
  endtask

  function automatic int m_pend();
    return (mrx[0] << 5) | (mtx[0] << 4) | (mrx[1] << 2) | (mtx[1] << 1);
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      mrx[c] = 0; mtx[c] = 0; mri[c] = 0; mti[c] = 0; mbrk[c] = 0;
    end
    mvec = 'h06;
    exp_irq = 0;
  endtask

  task automatic tick();
    int r = 0;
    for (int c = 0; c < 2; c++) begin
      int md = (rx_mode >> (2 * c)) & 3;
      if (ie_master[c] && ((ie_tx[c] && mtx[c] != 0) || ((md == 1 || md == 2) && mrx[c] != 0) ||
                           (ie_brk[c] && mbrk[c] != 0))) r = 1;
    end
    exp_irq = r;
    for (int c = 0; c < 2; c++) begin
      if (clr_ius[c]) begin
        if (mri[c] != 0) m_clr_rx(c);
        else if (mti[c] != 0) m_clr_tx(c);
      end
      if (data_rd[c]) m_clr_rx(c);
      if (clr_tx[c])  m_clr_tx(c);
      if (rx_evt[c])  m_set_rx(c);
      if (tx_evt[c])  m_set_tx(c);
      if (brk_evt[c]) mbrk[c] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(irq == exp_irq[0], "R3 irq vs model", irq, exp_irq);
    chk(vec == mvec[7:0], "R6 R7 vec vs model", vec, mvec);
    chk(pend == m_pend(), "R4 pend vs model", pend, m_pend());
    rx_evt = '0; tx_evt = '0; brk_evt = '0; data_rd = '0; clr_tx = '0; clr_ius = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(vec == 8'h06, "R1 vec after reset", vec, 'h06);
    chk(pend == 8'h00, "R1 pend after reset", pend, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    do_reset();
    // R6: A receive claims, low codes
    rx_evt = 2'b01; tick();
    chk(vec == 8'h0C, "R6 A rx code", vec, 'h0C);
    chk(pend == 8'h20, "R4 A rx bit", pend, 'h20);
    chk(irq == 1'b0, "R3 irq one cycle late", irq, 0);
    tick();
    chk(irq == 1'b1, "R3 irq raised", irq, 1);
    // R5: transmit pends but cannot claim
    tx_evt = 2'b01; tick();
    chk(vec == 8'h0C, "R5 tx blocked by rx in service", vec, 'h0C);
    chk(pend == 8'h30, "R5 both pending", pend, 'h30);
    // R10 and R8: read clears rx, tx promoted
    data_rd = 2'b01; tick();
    chk(vec == 8'h08, "R10 R8 read promotes tx", vec, 'h08);
    chk(pend == 8'h10, "R10 rx bit cleared", pend, 'h10);
    // R9: reset-highest clears tx in service
    clr_ius = 2'b01; tick();
    chk(vec == 8'h06, "R9 clears tx in service", vec, 'h06);
    chk(pend == 8'h00, "R9 pend empty", pend, 0);
    tick();
    // R7: high codes on channel B
    stat_hi = 1'b1;
    rx_evt = 2'b10; tick();
    chk(vec == 8'h20, "R7 B rx high code", vec, 'h20);
    tx_evt = 2'b10; tick();
    chk(pend == 8'h06, "R4 B bits", pend, 'h06);
    clr_tx = 2'b10; tick();
    chk(vec == 8'h20, "R8 clear tx re-asserts rx", vec, 'h20);
    clr_ius = 2'b10; tick();
    chk(vec == 8'h60, "R9 clears rx high none code", vec, 'h60);
    tx_evt = 2'b10; tick();
    chk(vec == 8'h00, "R7 B tx code", vec, 0);
    clr_ius = 2'b10; tick();
    chk(vec == 8'h60, "R8 tx clear none code", vec, 'h60);
    // R11: same-cycle ordering
    stat_hi = 1'b0;
    rx_evt = 2'b11; tick();
    chk(vec == 8'h04, "R11 channel B wins", vec, 'h04);
    data_rd = 2'b11; rx_evt = 2'b01; tick();
    chk(vec == 8'h06, "R11 B clear after A claim", vec, 'h06);
    chk(pend == 8'h20, "R11 read then receive keeps rx", pend, 'h20);
    data_rd = 2'b01; tick();
    // R2: enables gate the request
    ie_master = 2'b00; tick();
    rx_evt = 2'b01; tick(); tick();
    chk(irq == 1'b0, "R2 master off", irq, 0);
    ie_master = 2'b11; rx_mode = 4'b0111; tick(); tick();
    chk(irq == 1'b0, "R2 rx mode 11 off", irq, 0);
    rx_mode = 4'b0110; tick(); tick();
    chk(irq == 1'b1, "R2 rx mode 10 on", irq, 1);
    data_rd = 2'b01; tick(); tick();
    chk(irq == 1'b0, "R2 no source", irq, 0);
    ie_brk = 2'b01; brk_evt = 2'b01; tick(); tick();
    chk(irq == 1'b1, "R2 break request", irq, 1);
    ie_brk = 2'b00; tick(); tick();
    chk(irq == 1'b0, "R2 break disabled", irq, 0);
    ie_brk = 2'b01; tick(); tick();
    chk(irq == 1'b1, "R2 break status sticky", irq, 1);
    ie_brk = 2'b00; rx_mode = 4'b0101;
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      rx_evt  = 2'(($urandom % 6 == 0) | (($urandom % 6 == 0) << 1));
      tx_evt  = 2'(($urandom % 6 == 0) | (($urandom % 6 == 0) << 1));
      data_rd = 2'(($urandom % 7 == 0) | (($urandom % 7 == 0) << 1));
      clr_tx  = 2'(($urandom % 8 == 0) | (($urandom % 8 == 0) << 1));
      clr_ius = 2'(($urandom % 5 == 0) | (($urandom % 5 == 0) << 1));
      brk_evt = 2'(($urandom % 200 == 0) | (($urandom % 200 == 0) << 1));
      if ($urandom % 20 == 0) begin
        stat_hi   = 1'($urandom);
        ie_master = 2'($urandom);
        ie_tx     = 2'($urandom);
        ie_brk    = 2'($urandom);
        rx_mode   = 4'($urandom);
      end
      tick();
    end
    // R1: reset clears break status as well
    ie_master = 2'b11; ie_brk = 2'b11;
    do_reset();
    tick();
    chk(irq == 1'b0, "R1 break cleared by reset", irq, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule